// File: doc/BRIEF.md
# SPI Flash to RAM Boot Loader

This block fills the top of a 64 KB parallel RAM with a fixed-size image held in a serial SPI memory. It keeps the host processor in reset while it loads. When reset is released, it pulls chip select low and sends a read request for address zero. It then clocks in the memory's sequential output stream, assembles the bytes and writes each one to RAM. It uses its own address counter and a one-clock write strobe.

The image is 2^SIZE_LOG2 bytes long. SIZE_LOG2 is a parameter from 10 to 14, giving 1 KB to 16 KB. The image is placed at 0x10000 minus its size, so it always covers the reset vectors. When the last byte has been written, the loader deselects the SPI memory and stops SCK. It then releases the address and data drivers, raises a done flag and lets the processor run. It stays idle until the next external reset, which restarts the whole sequence.

SCK runs at half the system clock in SPI mode 0. MOSI changes after SCK falls, and MISO is sampled as SCK rises.

Top module: `spi_boot_loader`

## Requirements
- R1: While rst_ni is low, spi_cs_no is 1, spi_sck_o, spi_mosi_o, ram_we_o, bus_oe_o, done_o are 0 and cpu_rst_no is 0.
- R2: From the first clock after reset release until the end of the last write, spi_cs_no is 0 and bus_oe_o is 1. Outside that window, spi_cs_no is 1 and bus_oe_o is 0.
- R3: While selected, spi_sck_o is 0 in the first selected cycle and toggles every clock, so each SCK period is two clocks with the low half first. SCK is 0 while deselected.
- R4: The first 24 SCK periods carry, most significant bit first, the read command 0x03 followed by a 16-bit zero address. MOSI is stable while SCK is high.
- R5: After the 24th bit, spi_mosi_o stays 0 until the end of the load.
- R6: MISO is sampled on each SCK rise. Bits 24 onward form consecutive bytes, most significant bit first. Byte i is the i-th byte of the memory from address 0.
- R7: ram_we_o is high for exactly one clock, in the SCK-low half of the first bit after each data byte completes. ram_data_o holds that byte during the strobe.
- R8: The write address for byte i is 0x10000 - 2^SIZE_LOG2 + i. It stays at the base until the first strobe and steps by one after each strobe.
- R9: After exactly 2^SIZE_LOG2 strobes, the clock after the last strobe shows spi_cs_no at 1, SCK stopped, done_o at 1 and cpu_rst_no at 1. These outputs then hold until reset.
- R10: Asserting rst_ni in the middle of a load aborts it. Releasing rst_ni restarts the load from the command byte and byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, restarts the load |
| spi_sck_o | output | 1 | SPI serial clock, clk_i/2 |
| spi_cs_no | output | 1 | Active-low SPI chip select |
| spi_mosi_o | output | 1 | Serial command/address out |
| spi_miso_i | input | 1 | Serial data in |
| ram_addr_o | output | 16 | RAM write address |
| ram_data_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | Active-high RAM write strobe |
| bus_oe_o | output | 1 | Enable for the address and data bus drivers |
| cpu_rst_no | output | 1 | Active-low processor reset, released when done |
| done_o | output | 1 | Load complete |

## Verification
A reference counter in the bench advances one step per clock from the first edge after reset release. Every output is predicted from that step number h. SCK equals h mod 2, MOSI carries bit h/2 of the 24-bit request, a strobe falls on every h that is a multiple of 16 from 64 on with byte index h/16 - 4, and done is first seen at h = 16·(N+3) + 1. All outputs are sampled on the falling clock edge, half a cycle after the registers that drive them update. An asynchronous reset clears the reference in the same half cycle. A behavioural SPI memory checks the received request bits and drives MISO on SCK falls. After completion, the written RAM image and the write count are compared byte by byte.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_READ = 8'h03;

  typedef enum logic [1:0] {
    SLOT_CMD  = 2'd0,
    SLOT_AH   = 2'd1,
    SLOT_AL   = 2'd2,
    SLOT_DATA = 2'd3
  } slot_e;
endpackage

// File: rtl/sbl_seq.sv
module sbl_seq
  import sbl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic sck_o,
  output logic cs_n_o,
  output logic mosi_o,
  output logic cap_o,
  output logic wr_go_o
);
  logic       started_q;
  logic       run_q;
  logic       ph_q;
  logic [2:0] bit_q;
  slot_e      slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      run_q     <= 1'b0;
      ph_q      <= 1'b0;
      bit_q     <= '0;
      slot_q    <= SLOT_CMD;
    end else if (!started_q) begin
      started_q <= 1'b1;
      run_q     <= 1'b1;
    end else if (run_q) begin
      if (stop_i) begin
        run_q <= 1'b0;
        ph_q  <= 1'b0;
      end else begin
        ph_q <= ~ph_q;
        if (ph_q) begin
          bit_q <= bit_q + 3'd1;
          // slot saturates: everything from slot 3 on is data
          if (bit_q == 3'd7 && slot_q != SLOT_DATA) slot_q <= slot_e'(slot_q + 2'd1);
        end
      end
    end
  end

  assign sck_o   = run_q & ph_q;
  assign cs_n_o  = ~run_q;
  assign mosi_o  = run_q && (slot_q == SLOT_CMD) && CMD_READ[~bit_q];
  assign cap_o   = run_q & ~ph_q;
  assign wr_go_o = run_q && ph_q && (bit_q == 3'd7) && (slot_q == SLOT_DATA);

  p_sck_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !stop_i) |=> (sck_o != $past(sck_o)));

  p_sck_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sck_o);
endmodule

// File: rtl/sbl_shift.sv
module sbl_shift
  import sbl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              miso_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (cap_i) sh_q <= {sh_q[BYTE_W-2:0], miso_i};
  end

  assign byte_o = sh_q;
endmodule

// File: rtl/sbl_writer.sv
module sbl_writer
  import sbl_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_go_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              done_o
);
  localparam int unsigned NBYTES = 1 << SIZE_LOG2;
  localparam logic [SIZE_LOG2-1:0] LAST_IDX = SIZE_LOG2'(NBYTES - 1);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(32'h1_0000 - NBYTES);

  logic                 we_q;
  logic                 done_q;
  logic [SIZE_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      we_q <= wr_go_i & ~done_q;
      if (we_q) cnt_q <= cnt_q + 1'b1;
      if (last_o) done_q <= 1'b1;
    end
  end

  assign last_o = we_q && (cnt_q == LAST_IDX);
  assign we_o   = we_q;
  assign done_o = done_q;
  assign addr_o = BASE | {{(ADDR_W-SIZE_LOG2){1'b0}}, cnt_q};

  p_addr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_q |=> $stable(cnt_q));

  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import sbl_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 14
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        spi_sck_o,
  output logic        spi_cs_no,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i,
  output logic [15:0] ram_addr_o,
  output logic [7:0]  ram_data_o,
  output logic        ram_we_o,
  output logic        bus_oe_o,
  output logic        cpu_rst_no,
  output logic        done_o
);
  logic cap, wr_go, last, done;

  sbl_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stop_i  (last),
    .sck_o   (spi_sck_o),
    .cs_n_o  (spi_cs_no),
    .mosi_o  (spi_mosi_o),
    .cap_o   (cap),
    .wr_go_o (wr_go)
  );

  sbl_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .miso_i (spi_miso_i),
    .byte_o (ram_data_o)
  );

  sbl_writer #(.SIZE_LOG2(SIZE_LOG2)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_go_i (wr_go),
    .we_o    (ram_we_o),
    .addr_o  (ram_addr_o),
    .last_o  (last),
    .done_o  (done)
  );

  assign bus_oe_o   = ~spi_cs_no;
  assign done_o     = done;
  assign cpu_rst_no = done;

  p_we_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (!spi_cs_no && !spi_sck_o));

  p_we_mosi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> !spi_mosi_o);

  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> (spi_cs_no && !bus_oe_o));

  p_we_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o);
endmodule

// File: tb/spi_boot_loader_test.sv
`timescale 1ns/1ps
module spi_boot_loader_test;
  localparam int SZ   = 10;
  localparam int N    = 1 << SZ;
  localparam int BASE = 65536 - N;
  localparam int HL   = 16 * (N + 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck, cs_n, mosi, miso = 1'b0;
  logic [15:0] addr;
  logic [7:0]  data;
  logic we, oe, cpu_rst_n, done;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  spi_boot_loader #(.SIZE_LOG2(SZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .spi_sck_o(sck), .spi_cs_no(cs_n),
    .spi_mosi_o(mosi), .spi_miso_i(miso), .ram_addr_o(addr), .ram_data_o(data),
    .ram_we_o(we), .bus_oe_o(oe), .cpu_rst_no(cpu_rst_n), .done_o(done)
  );

  function automatic logic [7:0] fbyte(int i);
    return 8'(((i * 37) ^ (i >> 3)) + 5);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural SPI memory, mode 0
  int fb = 0;
  logic [23:0] req_sh = '0;
  int mosi_hi = 0;
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) fb = 0;
    else begin
      if (fb < 24) req_sh = {req_sh[22:0], mosi};
      else if (mosi) mosi_hi++;
      fb++;
    end
  end
  always @(negedge sck) begin
    if (!cs_n && fb >= 24) begin
      logic [7:0] bv;
      bv = fbyte((fb - 24) / 8);
      miso = bv[7 - ((fb - 24) % 8)];
    end
  end

  // reference: step counter since reset release
  int h = -1;
  bit m_done = 1'b0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h = -1;
      m_done = 1'b0;
    end else if (!m_done) begin
      if (h >= HL) begin
        m_done = 1'b1;
        h = -1;
      end else h = h + 1;
    end
  end

  // RAM image
  logic [7:0] ram [int];
  int wcount = 0;
  always @(negedge rst_n) begin
    ram.delete();
    wcount = 0;
    mosi_hi = 0;
  end

  always @(negedge clk) begin
    bit run;
    int b;
    run = (h >= 0);
    b = h / 2;
    if (!rst_n) begin
      chk(cs_n === 1'b1 && sck === 1'b0 && mosi === 1'b0 && we === 1'b0 &&
          oe === 1'b0 && done === 1'b0 && cpu_rst_n === 1'b0,
          "R1 reset state", {cs_n, sck, mosi, we, oe, done, cpu_rst_n}, 7'b1000000);
    end else begin
      chk(cs_n === !run, "R2 chip select", cs_n, !run);
      chk(oe === run, "R2 bus enable", oe, run);
      chk(sck === (run && (h % 2 == 1)), "R3 sck", sck, run && (h % 2 == 1));
      if (run && b < 24) begin
        chk(mosi === (b >= 6 && b < 8), "R4 request bit", mosi, (b >= 6 && b < 8));
      end else begin
        chk(mosi === 1'b0, "R5 mosi idle", mosi, 0);
      end
      chk(we === (run && h >= 64 && h % 16 == 0), "R7 strobe", we,
          run && h >= 64 && h % 16 == 0);
      chk(done === m_done, "R9 done", done, m_done);
      chk(cpu_rst_n === m_done, "R9 cpu reset", cpu_rst_n, m_done);
      if (run && h >= 64 && h % 16 == 0) begin
        int idx;
        idx = h / 16 - 4;
        chk(addr === 16'(BASE + idx), "R8 address", addr, BASE + idx);
        chk(data === fbyte(idx), "R6 data byte", data, fbyte(idx));
      end
      if (we === 1'b1) begin
        ram[int'(addr)] = data;
        wcount++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10: abort part way through the data phase
    while (h < 64 + 16 * 40) @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    while (!m_done) @(posedge clk);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(req_sh === 24'h030000, "R4 request word", req_sh, 24'h030000);
    chk(mosi_hi == 0, "R5 mosi after request", mosi_hi, 0);
    chk(wcount == N, "R10 R9 write count after restart", wcount, N);
    chk(ram.num() == N, "R8 distinct addresses", ram.num(), N);
    for (int i = 0; i < N; i++) begin
      if (!ram.exists(BASE + i)) chk(1'b0, "R8 missing byte", i, BASE + i);
      else chk(ram[BASE + i] === fbyte(i), "R6 R10 image byte", ram[BASE + i], fbyte(i));
    end
    chk(cs_n === 1'b1 && sck === 1'b0 && done === 1'b1, "R9 idle after done",
        {cs_n, sck, done}, 3'b101);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule